// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block holds the programming state of an interrupt router: a small identification register, a fixed version word and one 64-bit routing entry per interrupt pin (24 pins by default). Software never addresses these registers directly. It first writes an index into a select register at bus offset 0x00. It then reads or writes the chosen register, or one 32-bit half of a routing entry, through a data window at bus offset 0x10.

Every field of every entry is driven continuously on output ports, so that a separate delivery block can use them. That block reports back through three inputs: per-pin request levels, set/clear strobes for the remote-IRR bit, and a per-pin busy level that becomes the delivery-status bit. Software cannot overwrite either of these hardware-owned bits. The block raises a one-cycle notification when a write flips an entry's mask. It raises a one-cycle service request when a write leaves an entry in level mode while that pin is requesting.

Top module: `irq_route_regfile`

## Requirements
- R1: Bus offset 0x00 is the select register. A write there keeps bits 7:0 of the data, and a read returns that value zero-extended. Offset 0x10 is the data window. Every other offset reads 0, and writes to it change nothing.
- R2: Select index 0x01 is the version word. It reads NUM_PINS-1 in bits 23:16, VERSION_CODE in bits 7:0 and zero elsewhere. Window writes to it are ignored.
- R3: A window write with select index 0x00 stores data bits 27:24 as the 4-bit ID. Indices 0x00 and 0x02 both read the ID in bits 27:24 with every other bit zero. Writes to index 0x02 are ignored.
- R4: Select values 0x10 and above address entry (select-0x10)>>1. Select bit 0 set means bits 63:32 of the entry and clear means bits 31:0. The entry layout is: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote IRR 14, trigger 15 (1 = level, 0 = edge), mask 16, destination 63:56. All other bits store what was written. The fields appear on the ent_* ports one cycle after the write.
- R5: A window read with select 0x03 to 0x0F, or with an entry index at or above NUM_PINS, returns all ones. A window write to such an index changes no entry and raises no pulse.
- R6: A window write never changes the remote-IRR or delivery-status bit of the entry it writes.
- R7: An entry whose trigger bit is 0 after a window write has its remote IRR cleared on that same edge. This takes priority over rirr_set.
- R8: A window write that changes an entry's mask bit pulses mask_evt for one cycle, in the cycle after the write, with mask_evt_pin set to the pin and mask_evt_val set to the new mask. A write that leaves the mask unchanged raises no pulse.
- R9: A window write that leaves an entry level-triggered while pin_req for that pin is 1 pulses svc_req for one cycle, in the cycle after the write, with svc_pin set to the pin.
- R10: Reset sets every entry to mask = 1 with all other bits 0, clears the select register and the ID, and holds both pulses low.
- R11: rirr_set[p] sets and rirr_clr[p] clears the remote IRR of entry p, with set winning. Delivery status of entry p equals dlv_busy[p] from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 8 | Bus byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr and the select value |
| pin_req | input | NUM_PINS | Per-pin request level from the delivery side |
| rirr_set | input | NUM_PINS | Per-pin remote-IRR set strobe |
| rirr_clr | input | NUM_PINS | Per-pin remote-IRR clear strobe |
| dlv_busy | input | NUM_PINS | Per-pin delivery-in-progress level |
| ent_vector | output | 8*NUM_PINS | Vector of each entry |
| ent_dlv_mode | output | 3*NUM_PINS | Delivery mode of each entry |
| ent_dst_mode | output | NUM_PINS | Destination mode of each entry |
| ent_trig | output | NUM_PINS | Trigger mode, 1 = level |
| ent_mask | output | NUM_PINS | Mask bit of each entry |
| ent_dest | output | 8*NUM_PINS | Destination of each entry |
| ent_rirr | output | NUM_PINS | Remote IRR of each entry |
| ent_dstat | output | NUM_PINS | Delivery status of each entry |
| mask_evt | output | 1 | One-cycle mask-change pulse |
| mask_evt_pin | output | PIN_W | Pin of the last mask change |
| mask_evt_val | output | 1 | New mask value of the last mask change |
| svc_req | output | 1 | One-cycle delivery-attempt request |
| svc_pin | output | PIN_W | Pin of the last delivery-attempt request |

## Verification
Every entry bit is driven on the field ports without any read being needed. A bad merge of a window write, or a hardware-owned bit that was wrongly kept or lost, therefore shows on ent_* one cycle after the edge that caused it. The bench compares all entries after every cycle. A wrong select or ID value only shows when the window or select offset is read back, so the bench reads both after every cycle. A wrong pulse condition shows on mask_evt or svc_req in the cycle right after the offending write, and the bench checks the pulses on every cycle, including cycles with no write.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // One routing entry, most significant field first (bits 63..0).
    typedef struct packed {
        logic [7:0]  dest;   // 63:56
        logic [38:0] rsvd;   // 55:17, stored as written
        logic        mask;   // 16
        logic        trig;   // 15, 1 = level
        logic        rirr;   // 14, hardware owned
        logic        pol;    // 13
        logic        dstat;  // 12, hardware owned
        logic        dmode;  // 11
        logic [2:0]  dlv;    // 10:8
        logic [7:0]  vec;    // 7:0
    } route_ent_t;

    localparam logic [7:0]  OFFS_SELECT = 8'h00;
    localparam logic [7:0]  OFFS_WINDOW = 8'h10;

    localparam logic [7:0]  IDX_ID      = 8'h00;
    localparam logic [7:0]  IDX_VERSION = 8'h01;
    localparam logic [7:0]  IDX_ARB     = 8'h02;
    localparam logic [7:0]  IDX_TABLE   = 8'h10;

    localparam logic [63:0] ENT_RST     = 64'h0000_0000_0001_0000;

endpackage

// File: rtl/irq_route_entry.sv
module irq_route_entry
    import irq_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    input  logic        rirr_clr,
    input  logic        busy,
    output route_ent_t  ent_q,
    output logic        mask_flip,
    output logic        level_wr
);

    route_ent_t  ent_d;
    route_ent_t  merged;
    logic [63:0] raw;
    logic        wr_any;

    always_comb begin
        wr_any = wr_lo | wr_hi;
        raw    = ent_q;
        if (wr_lo) raw[31:0]  = wdata;
        if (wr_hi) raw[63:32] = wdata;
        merged = route_ent_t'(raw);

        // Software-visible fields follow the merge; owned bits do not.
        ent_d       = merged;
        ent_d.dstat = busy;
        if (rirr_set)      ent_d.rirr = 1'b1;
        else if (rirr_clr) ent_d.rirr = 1'b0;
        else               ent_d.rirr = ent_q.rirr;
        if (wr_any && !merged.trig) ent_d.rirr = 1'b0;

        mask_flip = wr_any && (merged.mask != ent_q.mask);
        level_wr  = wr_any && merged.trig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= route_ent_t'(ENT_RST);
        else        ent_q <= ent_d;
    end

endmodule

// File: rtl/irq_route_window.sv
module irq_route_window
    import irq_route_pkg::*;
#(
    parameter int         NUM_PINS     = 24,
    parameter logic [7:0] VERSION_CODE = 8'h11
) (
    input  logic                       bus_wr,
    input  logic [7:0]                 bus_addr,
    input  logic [7:0]                 sel,
    input  logic [3:0]                 id,
    input  route_ent_t [NUM_PINS-1:0]  ents,
    output logic [31:0]                rdata,
    output logic                       wr_sel,
    output logic                       wr_id,
    output logic [NUM_PINS-1:0]        wr_lo,
    output logic [NUM_PINS-1:0]        wr_hi
);

    localparam logic [7:0] TOP_IDX = 8'(NUM_PINS - 1);

    logic [7:0]  tbl_off;
    logic [6:0]  tbl_idx;
    logic        in_tbl;
    logic        win_wr;
    logic [63:0] hit;
    logic [31:0] win_rd;

    always_comb begin
        tbl_off = sel - IDX_TABLE;
        tbl_idx = tbl_off[7:1];
        in_tbl  = (sel >= IDX_TABLE) && ({25'd0, tbl_idx} < NUM_PINS);
        win_wr  = bus_wr && (bus_addr == OFFS_WINDOW);
        wr_sel  = bus_wr && (bus_addr == OFFS_SELECT);
        wr_id   = win_wr && (sel == IDX_ID);

        hit = '1;
        for (int p = 0; p < NUM_PINS; p++) begin
            wr_lo[p] = win_wr && in_tbl && (tbl_idx == 7'(p)) && !sel[0];
            wr_hi[p] = win_wr && in_tbl && (tbl_idx == 7'(p)) &&  sel[0];
            if (in_tbl && (tbl_idx == 7'(p))) hit = ents[p];
        end

        case (sel)
            IDX_ID, IDX_ARB: win_rd = {4'h0, id, 24'h0};
            IDX_VERSION:     win_rd = {8'h00, TOP_IDX, 8'h00, VERSION_CODE};
            default:         win_rd = sel[0] ? hit[63:32] : hit[31:0];
        endcase

        if (bus_addr == OFFS_SELECT)      rdata = {24'h0, sel};
        else if (bus_addr == OFFS_WINDOW) rdata = win_rd;
        else                              rdata = 32'h0;
    end

endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
    import irq_route_pkg::*;
#(
    parameter int         NUM_PINS     = 24,
    parameter logic [7:0] VERSION_CODE = 8'h11,
    localparam int        PIN_W        = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [7:0]              bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [NUM_PINS-1:0]     pin_req,
    input  logic [NUM_PINS-1:0]     rirr_set,
    input  logic [NUM_PINS-1:0]     rirr_clr,
    input  logic [NUM_PINS-1:0]     dlv_busy,
    output logic [8*NUM_PINS-1:0]   ent_vector,
    output logic [3*NUM_PINS-1:0]   ent_dlv_mode,
    output logic [NUM_PINS-1:0]     ent_dst_mode,
    output logic [NUM_PINS-1:0]     ent_trig,
    output logic [NUM_PINS-1:0]     ent_mask,
    output logic [8*NUM_PINS-1:0]   ent_dest,
    output logic [NUM_PINS-1:0]     ent_rirr,
    output logic [NUM_PINS-1:0]     ent_dstat,
    output logic                    mask_evt,
    output logic [PIN_W-1:0]        mask_evt_pin,
    output logic                    mask_evt_val,
    output logic                    svc_req,
    output logic [PIN_W-1:0]        svc_pin
);

    typedef struct packed {
        logic [7:0]       sel;
        logic [3:0]       id;
        logic             mevt;
        logic [PIN_W-1:0] mpin;
        logic             mval;
        logic             sreq;
        logic [PIN_W-1:0] spin;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    route_ent_t [NUM_PINS-1:0] ents;
    logic [NUM_PINS-1:0]       wr_lo, wr_hi, flip, lvl;
    logic                      wr_sel, wr_id;
    logic [7:0]                sel_q;
    logic [3:0]                id_q;

    assign sel_q = ctl_q.sel;
    assign id_q  = ctl_q.id;

    irq_route_window #(
        .NUM_PINS     (NUM_PINS),
        .VERSION_CODE (VERSION_CODE)
    ) u_window (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .sel      (sel_q),
        .id       (id_q),
        .ents     (ents),
        .rdata    (bus_rdata),
        .wr_sel   (wr_sel),
        .wr_id    (wr_id),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        irq_route_entry u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (wr_lo[p]),
            .wr_hi     (wr_hi[p]),
            .wdata     (bus_wdata),
            .rirr_set  (rirr_set[p]),
            .rirr_clr  (rirr_clr[p]),
            .busy      (dlv_busy[p]),
            .ent_q     (ents[p]),
            .mask_flip (flip[p]),
            .level_wr  (lvl[p])
        );

        assign ent_vector[8*p +: 8]   = ents[p].vec;
        assign ent_dlv_mode[3*p +: 3] = ents[p].dlv;
        assign ent_dst_mode[p]        = ents[p].dmode;
        assign ent_trig[p]            = ents[p].trig;
        assign ent_mask[p]            = ents[p].mask;
        assign ent_dest[8*p +: 8]     = ents[p].dest;
        assign ent_rirr[p]            = ents[p].rirr;
        assign ent_dstat[p]           = ents[p].dstat;
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.mevt = 1'b0;
        ctl_d.sreq = 1'b0;
        if (wr_sel) ctl_d.sel = bus_wdata[7:0];
        if (wr_id)  ctl_d.id  = bus_wdata[27:24];
        for (int p = 0; p < NUM_PINS; p++) begin
            if (flip[p]) begin
                ctl_d.mevt = 1'b1;
                ctl_d.mpin = PIN_W'(p);
                ctl_d.mval = ~ents[p].mask;
            end
            if (lvl[p] && pin_req[p]) begin
                ctl_d.sreq = 1'b1;
                ctl_d.spin = PIN_W'(p);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mask_evt     = ctl_q.mevt;
    assign mask_evt_pin = ctl_q.mpin;
    assign mask_evt_val = ctl_q.mval;
    assign svc_req      = ctl_q.sreq;
    assign svc_pin      = ctl_q.spin;

endmodule

// File: rtl/irq_route_regfile_chk.sv
module irq_route_regfile_chk #(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [7:0]          bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [7:0]          sel_q,
    input logic [3:0]          id_q,
    input logic [NUM_PINS-1:0] ent_trig,
    input logic [NUM_PINS-1:0] ent_rirr,
    input logic [NUM_PINS-1:0] ent_mask,
    input logic [NUM_PINS-1:0] rirr_set,
    input logic                mask_evt,
    input logic                svc_req,
    input logic [PIN_W-1:0]    svc_pin
);

    a_r1_select_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h00) |=> (sel_q == $past(bus_wdata[7:0])));

    a_r3_id_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(id_q) |-> $past(bus_wr && bus_addr == 8'h10 && sel_q == 8'h00));

    a_r8_mask_moves_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ent_mask) |-> ($past(bus_wr && bus_addr == 8'h10) && mask_evt));

    a_r9_service_level_only: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> (ent_trig[svc_pin] && $past(bus_wr && bus_addr == 8'h10)));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
        a_r7_edge_drops_rirr: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 8'h10 && sel_q >= 8'h10 &&
             8'((sel_q - 8'h10) >> 1) == 8'(p))
            |=> (ent_trig[p] || !ent_rirr[p]));

        a_r6_rirr_rises_by_hw: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ent_rirr[p]) |-> $past(rirr_set[p]));
    end

endmodule

bind irq_route_regfile irq_route_regfile_chk #(
    .NUM_PINS (NUM_PINS),
    .PIN_W    (PIN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sel_q     (sel_q),
    .id_q      (id_q),
    .ent_trig  (ent_trig),
    .ent_rirr  (ent_rirr),
    .ent_mask  (ent_mask),
    .rirr_set  (rirr_set),
    .mask_evt  (mask_evt),
    .svc_req   (svc_req),
    .svc_pin   (svc_pin)
);

// File: tb/irq_route_regfile_bench.sv
`timescale 1ns/10ps
module irq_route_regfile_bench;

    localparam int         NP  = 24;
    localparam int         PW  = 5;
    localparam logic [7:0] VER = 8'h11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     pin_req = '0, rirr_set = '0, rirr_clr = '0, dlv_busy = '0;
    logic [8*NP-1:0]   ent_vector, ent_dest;
    logic [3*NP-1:0]   ent_dlv_mode;
    logic [NP-1:0]     ent_dst_mode, ent_trig, ent_mask, ent_rirr, ent_dstat;
    logic              mask_evt, mask_evt_val, svc_req;
    logic [PW-1:0]     mask_evt_pin, svc_pin;

    always #2 clk = ~clk;

    irq_route_regfile #(.NUM_PINS(NP), .VERSION_CODE(VER)) u_irq_route_regfile (.*);

    int n_run = 0;
    int n_fail = 0;

    logic [63:0] m_ent [NP];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;
    logic        e_mevt, e_mval, e_sreq;
    int          e_mpin, e_spin;

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_win(input logic [7:0] s);
        int idx;
        if (s == 8'h00 || s == 8'h02) return {4'h0, m_id, 24'h0};
        if (s == 8'h01) return {8'h00, 8'(NP - 1), 8'h00, VER};
        if (s < 8'h10) return 32'hFFFF_FFFF;
        idx = (int'(s) - 16) / 2;
        if (idx >= NP) return 32'hFFFF_FFFF;
        return s[0] ? m_ent[idx][63:32] : m_ent[idx][31:0];
    endfunction

    function automatic string f_tag(input logic [7:0] s);
        if (s <= 8'h02) return "R2 R3 id/version window";
        if (s < 8'h10 || ((int'(s) - 16) / 2) >= NP) return "R5 out-of-range window";
        return "R4 entry window";
    endfunction

    task automatic check_ports(input string pre);
        logic [8*NP-1:0] ev, ed;
        logic [3*NP-1:0] edl;
        logic [NP-1:0]   edm, etr, emk, er, es;
        for (int p = 0; p < NP; p++) begin
            ev[8*p +: 8]  = m_ent[p][7:0];
            edl[3*p +: 3] = m_ent[p][10:8];
            edm[p]        = m_ent[p][11];
            es[p]         = m_ent[p][12];
            er[p]         = m_ent[p][14];
            etr[p]        = m_ent[p][15];
            emk[p]        = m_ent[p][16];
            ed[8*p +: 8]  = m_ent[p][63:56];
        end
        chk(ent_vector == ev, {pre, " R4 vector"}, 256'(ent_vector), 256'(ev));
        chk(ent_dlv_mode == edl && ent_dst_mode == edm, {pre, " R4 modes"},
            256'({ent_dlv_mode, ent_dst_mode}), 256'({edl, edm}));
        chk(ent_trig == etr, {pre, " R4 trigger"}, 256'(ent_trig), 256'(etr));
        chk(ent_mask == emk, {pre, " R4 R10 mask"}, 256'(ent_mask), 256'(emk));
        chk(ent_dest == ed, {pre, " R4 dest"}, 256'(ent_dest), 256'(ed));
        chk(ent_rirr == er, {pre, " R6 R7 R11 remote IRR"}, 256'(ent_rirr), 256'(er));
        chk(ent_dstat == es, {pre, " R6 R11 delivery status"}, 256'(ent_dstat), 256'(es));
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_wr   = 1'b0;
        bus_addr = a;
        #0.1;
        chk(bus_rdata == exp, tag, 256'(bus_rdata), 256'(exp));
    endtask

    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [NP-1:0] req, input logic [NP-1:0] st,
                        input logic [NP-1:0] cl, input logic [NP-1:0] bz);
        int          widx;
        logic [63:0] mrg;
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        pin_req = req; rirr_set = st; rirr_clr = cl; dlv_busy = bz;
        widx = -1; mrg = '0; e_mevt = 1'b0; e_sreq = 1'b0;
        if (wr && a == 8'h10) begin
            if (m_sel == 8'h00) m_id = d[27:24];
            else if (m_sel >= 8'h10 && ((int'(m_sel) - 16) / 2) < NP) begin
                widx = (int'(m_sel) - 16) / 2;
                mrg  = m_ent[widx];
                if (m_sel[0]) mrg[63:32] = d; else mrg[31:0] = d;
                if (mrg[16] != m_ent[widx][16]) begin
                    e_mevt = 1'b1; e_mpin = widx; e_mval = mrg[16];
                end
                if (mrg[15] && req[widx]) begin
                    e_sreq = 1'b1; e_spin = widx;
                end
            end
        end
        for (int p = 0; p < NP; p++) begin
            logic [63:0] nv;
            nv = (p == widx) ? mrg : m_ent[p];
            if (p == widx && !mrg[15]) nv[14] = 1'b0;
            else if (st[p])            nv[14] = 1'b1;
            else if (cl[p])            nv[14] = 1'b0;
            else                       nv[14] = m_ent[p][14];
            nv[12]   = bz[p];
            m_ent[p] = nv;
        end
        if (wr && a == 8'h00) m_sel = d[7:0];
        @(posedge clk);
        #1;
        chk(mask_evt == e_mevt, "R8 mask pulse", 256'(mask_evt), 256'(e_mevt));
        if (e_mevt)
            chk(mask_evt_pin == PW'(e_mpin) && mask_evt_val == e_mval, "R8 mask pin/value",
                256'({mask_evt_pin, mask_evt_val}), 256'({PW'(e_mpin), e_mval}));
        chk(svc_req == e_sreq, "R9 service pulse", 256'(svc_req), 256'(e_sreq));
        if (e_sreq)
            chk(svc_pin == PW'(e_spin), "R9 service pin", 256'(svc_pin), 256'(PW'(e_spin)));
        check_ports("step");
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20417));
        for (int p = 0; p < NP; p++) m_ent[p] = 64'h0000_0000_0001_0000;
        m_sel = '0; m_id = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        // R10: reset state
        check_ports("R10 reset");
        chk(!mask_evt && !svc_req, "R10 no pulses", 256'({mask_evt, svc_req}), 256'(0));
        rd(8'h00, 32'h0, "R10 select cleared");
        rd(8'h10, 32'h0, "R10 id cleared");

        // R2: version word, read-only
        step(1, 8'h00, 32'hABCD_1201, '0, '0, '0, '0);
        rd(8'h00, 32'h01, "R1 select keeps low byte");
        rd(8'h10, f_win(8'h01), "R2 version");
        step(1, 8'h10, 32'hFFFF_FFFF, '0, '0, '0, '0);
        rd(8'h10, {8'h00, 8'(NP - 1), 8'h00, VER}, "R2 version write ignored");

        // R3: ID and arbitration
        step(1, 8'h00, 32'h0, '0, '0, '0, '0);
        step(1, 8'h10, 32'hA5FF_FFFF, '0, '0, '0, '0);
        rd(8'h10, 32'h0500_0000, "R3 id stored");
        step(1, 8'h00, 32'h2, '0, '0, '0, '0);
        rd(8'h10, 32'h0500_0000, "R3 arbitration reads id");
        step(1, 8'h10, 32'h0F00_0000, '0, '0, '0, '0);
        rd(8'h10, 32'h0500_0000, "R3 arbitration write ignored");

        // R1: other offsets
        step(1, 8'h04, 32'h0000_0055, '0, '0, '0, '0);
        rd(8'h04, 32'h0, "R1 other offset reads zero");
        rd(8'h00, 32'h02, "R1 other offset write ignored");

        // R5: out-of-range indices
        step(1, 8'h00, 32'h05, '0, '0, '0, '0);
        rd(8'h10, 32'hFFFF_FFFF, "R5 low gap reads ones");
        step(1, 8'h00, 32'(8'h10 + 2 * NP), '0, '0, '0, '0);
        rd(8'h10, 32'hFFFF_FFFF, "R5 past last pin reads ones");
        step(1, 8'h10, 32'h0000_8000, '1, '0, '0, '0);

        // R6 R7 R8 R9 R11 on pin 0
        step(1, 8'h00, 32'h10, '0, '0, '0, '0);
        step(1, 8'h10, 32'h0000_8031, 24'h1, '0, '0, '0);
        step(0, 8'h00, 32'h0, '0, 24'h1, '0, 24'h1);
        step(1, 8'h10, 32'h0000_8031, '0, '0, '0, 24'h1);
        rd(8'h10, f_win(8'h10), "R6 window keeps owned bits");
        step(1, 8'h10, 32'h0001_0031, '0, 24'h1, '0, '0);
        step(1, 8'h00, 32'h11, '0, '0, '0, '0);
        step(1, 8'h10, 32'h7700_0000, '0, '0, '0, '0);
        rd(8'h10, 32'h7700_0000, "R4 high half");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int unsigned  op;
            logic [31:0]  d;
            logic [NP-1:0] st, cl;
            op = $urandom % 10;
            d  = $urandom;
            st = NP'($urandom & $urandom & $urandom);
            cl = NP'($urandom & $urandom & $urandom);
            if (op < 3) begin
                if ($urandom % 4 == 0) d[7:0] = 8'($urandom % 4);
                else d[7:0] = 8'(8'h10 + ($urandom % (2 * NP + 6)));
                step(1, 8'h00, d, NP'($urandom), st, cl, NP'($urandom));
            end else if (op < 7) begin
                step(1, 8'h10, d, NP'($urandom), st, cl, NP'($urandom));
            end else if (op == 7) begin
                step(1, 8'(($urandom % 15 + 1) * 4), d, NP'($urandom), st, cl, NP'($urandom));
            end else begin
                step(0, 8'h10, d, NP'($urandom), st, cl, NP'($urandom));
            end
            rd(8'h10, f_win(m_sel), f_tag(m_sel));
            rd(8'h00, {24'h0, m_sel}, "R1 select readback");
        end
        finish_run();
    end

endmodule